// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block keeps the device-side bookkeeping for one receive DMA channel whose host buffers are listed in a circular descriptor ring. The host publishes how far it has stocked the ring by writing a write index. The block owns the read index, which names the buffer currently being filled. It decides whether an incoming frame may start, adds beat byte counts into the open buffer, and closes that buffer when it is full or when it has sat idle too long. On each close it reports the closed descriptor index and, if enabled, raises a host interrupt.

A single 32-bit configuration word sets the ring size, buffer size, idle timeout, interrupt routing and channel mode. The channel can run, stop at once, or finish the current frame before it stops. A status word combines the idle flag with the last closed index. Frames that cannot be placed are discarded and counted in a saturating overflow counter. Data movement, host address generation and descriptor contents belong to neighbouring logic.

Top module: `rx_ring_ctrl`

## Requirements
- R1: After reset, `last_idx` is 0, `host_irq` is 0, `ovf_cnt` is 0, `chan_idle` is 1 and `status_word` reads 32'h0100_0000.
- R2: The ring holds 2^N descriptors, with N taken from config bits 23:20 and clamped to the range 5..12. The read index wraps to 0 after descriptor 2^N-1, and `last_idx` never exceeds 2^N-1.
- R3: A write-index write takes effect one cycle later, masked to the ring size, only when its low three bits are zero. A write with any of those bits set is ignored.
- R4: When the read index equals the host write index, no buffer is free. A frame start (`frm_sof` with `frm_valid`) in run mode at that moment is discarded up to its end marker, and `ovf_cnt` rises by one. `ovf_cnt` saturates at its maximum.
- R5: Config bits 17:16 set the buffer capacity to (code+1)×4096 bytes. An accepted beat that brings the buffer fill to at least the capacity closes the buffer at that edge.
- R6: Config bits 11:4 give a timeout T in tick periods. A buffer holding data closes on the T-th `tick_32us` after its last accepted beat. T = 0 disables the timeout.
- R7: Every close raises `host_irq` for exactly one cycle when config bits 13:12 equal 01. Any other value of those bits gives no pulse.
- R8: `last_idx` (also `status_word` bits 11:0) shows the index of the most recently closed descriptor, from the cycle after the closing edge.
- R9: Config bits 31:30 select the mode: 10 runs. 00 (and 11) stop at once: every beat is ignored and a frame in progress is abandoned.
- R10: Mode 01 lets the frame in progress finish, refuses new frames without counting them as overflow, and reports idle once the end marker is taken.
- R11: `status_word` bit 24 equals `chan_idle`. Writing a config word of zero makes the channel idle from the next cycle.
- R12: When a buffer closes in the middle of an accepted frame and the next descriptor is not free, the rest of that frame is discarded and `ovf_cnt` rises by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Config word write strobe |
| cfg_wdata | input | 32 | Config word |
| widx_wr | input | 1 | Host write-index write strobe |
| widx_wdata | input | IDX_W | Host write index |
| frm_valid | input | 1 | Frame beat present |
| frm_sof | input | 1 | Beat opens a frame |
| frm_eof | input | 1 | Beat ends a frame |
| frm_bytes | input | BCNT_W | Bytes carried by the beat |
| tick_32us | input | 1 | One-cycle pulse per 32 µs period |
| last_idx | output | IDX_W | Index of last closed descriptor |
| host_irq | output | 1 | Host interrupt pulse |
| chan_idle | output | 1 | Channel idle flag |
| status_word | output | 32 | Bit 24 idle, bits 11:0 last closed index |
| ovf_cnt | output | OVF_W | Saturating count of discarded frames |

## Verification
The bench keeps the default 12-bit index and 11-bit beat count, so a ring can be set as small as 32 entries. That brings index wrap, a full ring and a close in the middle of a frame into reach within a few hundred cycles. It narrows the overflow counter to 4 bits so that random traffic drives it into saturation. Random config writes include ring-size codes below 5 and above 12, which exercises the clamping.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;
    localparam int CFG_W    = 32;
    localparam int IDLE_BIT = 24;

    typedef enum logic [1:0] {
        MODE_STOP = 2'b00,
        MODE_EOF  = 2'b01,
        MODE_RUN  = 2'b10,
        MODE_HALT = 2'b11
    } rxr_mode_e;

    localparam logic [1:0] IRQ_TO_HOST = 2'b01;

    // Fields kept from a config write; reserved bits are dropped.
    typedef struct packed {
        rxr_mode_e  mode;
        logic [3:0] ring_log;
        logic [1:0] buf_sz;
        logic [1:0] irq_dst;
        logic [7:0] tmo;
    } rxr_cfg_t;

    function automatic rxr_cfg_t rxr_decode(input logic [CFG_W-1:0] w);
        rxr_cfg_t c;
        c.mode     = rxr_mode_e'(w[31:30]);
        c.ring_log = w[23:20];
        c.buf_sz   = w[17:16];
        c.irq_dst  = w[13:12];
        c.tmo      = w[11:4];
        return c;
    endfunction
endpackage

// File: rtl/rxr_ring.sv
`timescale 1ns/1ps
module rxr_ring #(
    parameter int IDX_W   = 12,
    parameter int MIN_LOG = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       ring_log,
    input  logic             widx_wr,
    input  logic [IDX_W-1:0] widx_wdata,
    input  logic             close,
    output logic [IDX_W-1:0] rd_idx,
    output logic [IDX_W-1:0] last_idx,
    output logic             free_now,
    output logic             free_next
);
    localparam int MAX_LOG  = IDX_W;
    localparam int STEP_LOG = 3;

    typedef struct packed {
        logic [IDX_W-1:0] widx;
        logic [IDX_W-1:0] rd;
        logic [IDX_W-1:0] last;
    } ring_st_t;

    ring_st_t         st_d, st_q;
    int               eff_log;
    logic [IDX_W-1:0] idx_mask;
    logic [IDX_W-1:0] rd_nxt;

    always_comb begin
        eff_log = int'(ring_log);
        if (eff_log < MIN_LOG) eff_log = MIN_LOG;
        if (eff_log > MAX_LOG) eff_log = MAX_LOG;
        idx_mask  = IDX_W'((64'd1 << eff_log) - 64'd1);
        rd_nxt    = (st_q.rd + 1'b1) & idx_mask;
        free_now  = ((st_q.rd ^ st_q.widx) & idx_mask) != '0;
        free_next = ((rd_nxt ^ st_q.widx) & idx_mask) != '0;

        st_d = st_q;
        if (close) begin
            st_d.last = st_q.rd & idx_mask;
            st_d.rd   = rd_nxt;
        end
        if (widx_wr && widx_wdata[STEP_LOG-1:0] == '0)
            st_d.widx = widx_wdata & idx_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_idx   = st_q.rd & idx_mask;
    assign last_idx = st_q.last;
endmodule

// File: rtl/rxr_gate.sv
`timescale 1ns/1ps
module rxr_gate
    import rxr_pkg::*;
#(
    parameter int OVF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rxr_mode_e        mode,
    input  logic             frm_valid,
    input  logic             frm_sof,
    input  logic             frm_eof,
    input  logic             free_now,
    input  logic             free_next,
    input  logic             close,
    output logic             acc,
    output logic             in_frame,
    output logic [OVF_W-1:0] ovf_cnt
);
    typedef struct packed {
        logic             in_frame;
        logic             drop;
        logic [OVF_W-1:0] ovf;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic     ovf_inc;
    logic     open_mode;

    // Acceptance depends only on registered state and inputs.
    always_comb begin
        open_mode = (mode == MODE_RUN) || (mode == MODE_EOF);
        acc = 1'b0;
        if (open_mode && frm_valid) begin
            if (frm_sof) acc = (mode == MODE_RUN) && free_now;
            else         acc = st_q.in_frame;
        end
    end

    always_comb begin
        st_d    = st_q;
        ovf_inc = 1'b0;
        if (!open_mode) begin
            st_d.in_frame = 1'b0;
            st_d.drop     = 1'b0;
        end else if (frm_valid && frm_sof) begin
            st_d.in_frame = acc && !frm_eof;
            st_d.drop     = !acc && !frm_eof;
            if (mode == MODE_RUN && !free_now) ovf_inc = 1'b1;
        end else if (frm_valid && frm_eof) begin
            st_d.in_frame = 1'b0;
            st_d.drop     = 1'b0;
        end
        if (close && st_d.in_frame && !free_next) begin
            st_d.in_frame = 1'b0;
            st_d.drop     = 1'b1;
            ovf_inc       = 1'b1;
        end
        if (ovf_inc && st_q.ovf != '1) st_d.ovf = st_q.ovf + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_frame = st_q.in_frame;
    assign ovf_cnt  = st_q.ovf;
endmodule

// File: rtl/rxr_fill.sv
`timescale 1ns/1ps
module rxr_fill
    import rxr_pkg::*;
#(
    parameter int BCNT_W   = 11,
    parameter int FILL_W   = 15,
    parameter int BUF_UNIT = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic [BCNT_W-1:0] bytes,
    input  logic [1:0]        buf_sz,
    input  logic [7:0]        tmo,
    input  logic              tick,
    input  logic [1:0]        irq_dst,
    output logic              close,
    output logic              irq
);
    localparam int SUM_W = FILL_W + 1;

    typedef struct packed {
        logic [FILL_W-1:0] fill;
        logic [7:0]        tcnt;
        logic              irq;
    } fill_st_t;

    fill_st_t          st_d, st_q;
    logic [SUM_W-1:0]  sum;
    logic [SUM_W-1:0]  cap;
    logic [8:0]        tcnt_inc;

    always_comb begin
        cap      = SUM_W'((int'(buf_sz) + 1) * BUF_UNIT);
        sum      = {1'b0, st_q.fill} + SUM_W'(bytes);
        tcnt_inc = {1'b0, st_q.tcnt} + 9'd1;
        close    = 1'b0;
        st_d     = st_q;
        if (acc) begin
            st_d.tcnt = '0;
            if (sum >= cap) begin
                close     = 1'b1;
                st_d.fill = '0;
            end else begin
                st_d.fill = sum[FILL_W-1:0];
            end
        end else if (tick && st_q.fill != '0 && tmo != '0) begin
            if (tcnt_inc == {1'b0, tmo}) begin
                close     = 1'b1;
                st_d.fill = '0;
                st_d.tcnt = '0;
            end else begin
                st_d.tcnt = tcnt_inc[7:0];
            end
        end
        st_d.irq = close && (irq_dst == IRQ_TO_HOST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;
endmodule

// File: rtl/rx_ring_ctrl.sv
`timescale 1ns/1ps
module rx_ring_ctrl
    import rxr_pkg::*;
#(
    parameter int IDX_W    = 12,
    parameter int MIN_LOG  = 5,
    parameter int BCNT_W   = 11,
    parameter int FILL_W   = 15,
    parameter int BUF_UNIT = 4096,
    parameter int OVF_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [31:0]       cfg_wdata,
    input  logic              widx_wr,
    input  logic [IDX_W-1:0]  widx_wdata,
    input  logic              frm_valid,
    input  logic              frm_sof,
    input  logic              frm_eof,
    input  logic [BCNT_W-1:0] frm_bytes,
    input  logic              tick_32us,
    output logic [IDX_W-1:0]  last_idx,
    output logic              host_irq,
    output logic              chan_idle,
    output logic [31:0]       status_word,
    output logic [OVF_W-1:0]  ovf_cnt
);
    rxr_cfg_t         cfg_d, cfg_q;
    logic             beat_acc;
    logic             buf_close;
    logic             free_now;
    logic             free_next;
    logic             in_frame;
    logic [IDX_W-1:0] rd_idx;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) cfg_d = rxr_decode(cfg_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    rxr_ring #(.IDX_W(IDX_W), .MIN_LOG(MIN_LOG)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .ring_log   (cfg_q.ring_log),
        .widx_wr    (widx_wr),
        .widx_wdata (widx_wdata),
        .close      (buf_close),
        .rd_idx     (rd_idx),
        .last_idx   (last_idx),
        .free_now   (free_now),
        .free_next  (free_next)
    );

    rxr_gate #(.OVF_W(OVF_W)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (cfg_q.mode),
        .frm_valid (frm_valid),
        .frm_sof   (frm_sof),
        .frm_eof   (frm_eof),
        .free_now  (free_now),
        .free_next (free_next),
        .close     (buf_close),
        .acc       (beat_acc),
        .in_frame  (in_frame),
        .ovf_cnt   (ovf_cnt)
    );

    rxr_fill #(.BCNT_W(BCNT_W), .FILL_W(FILL_W), .BUF_UNIT(BUF_UNIT)) u_fill (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (beat_acc),
        .bytes   (frm_bytes),
        .buf_sz  (cfg_q.buf_sz),
        .tmo     (cfg_q.tmo),
        .tick    (tick_32us),
        .irq_dst (cfg_q.irq_dst),
        .close   (buf_close),
        .irq     (host_irq)
    );

    always_comb begin
        chan_idle = (cfg_q.mode != MODE_RUN) &&
                    !((cfg_q.mode == MODE_EOF) && in_frame);
        status_word = '0;
        status_word[IDLE_BIT]    = chan_idle;
        status_word[IDX_W-1:0]   = last_idx;
    end
endmodule

// File: rtl/rxr_checker.sv
`timescale 1ns/1ps
module rxr_checker #(
    parameter int IDX_W = 12,
    parameter int OVF_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [31:0]      cfg_wdata,
    input logic             widx_wr,
    input logic [IDX_W-1:0] widx_wdata,
    input logic             frm_valid,
    input logic             frm_sof,
    input logic             host_irq,
    input logic             chan_idle,
    input logic [IDX_W-1:0] last_idx,
    input logic [OVF_W-1:0] ovf_cnt,
    input logic             beat_acc,
    input logic             buf_close,
    input logic             free_now,
    input logic [IDX_W-1:0] rd_idx
);
    a_r4_start_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && frm_sof && beat_acc) |-> free_now);

    a_r4_ovf_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_cnt == '1) |=> (ovf_cnt == '1));

    a_r12_ovf_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_cnt != '1) |=> (ovf_cnt >= $past(ovf_cnt)));

    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |=> !host_irq);

    a_r8_last_follows_close: assert property (@(posedge clk) disable iff (!rst_n)
        buf_close |=> (last_idx == $past(rd_idx)));

    a_r11_zero_cfg_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata == 32'h0) |=> chan_idle);

    a_r9_stop_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[31:30] == 2'b00) |=> !beat_acc);

    a_r3_misaligned_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (widx_wr && widx_wdata[2:0] != 3'b000 && !cfg_wr && !buf_close)
        |=> $stable(free_now));
endmodule

bind rx_ring_ctrl rxr_checker #(.IDX_W(IDX_W), .OVF_W(OVF_W)) i_rxr_checker (.*);

// File: tb/test_rx_ring_ctrl.sv
`timescale 1ns/1ps
module test_rx_ring_ctrl;
    localparam int IDX_W  = 12;
    localparam int BCNT_W = 11;
    localparam int OVF_W  = 4;
    localparam int OVF_MAX = (1 << OVF_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [31:0]       cfg_wdata = '0;
    logic              widx_wr = 1'b0;
    logic [IDX_W-1:0]  widx_wdata = '0;
    logic              frm_valid = 1'b0, frm_sof = 1'b0, frm_eof = 1'b0;
    logic [BCNT_W-1:0] frm_bytes = '0;
    logic              tick_32us = 1'b0;
    logic [IDX_W-1:0]  last_idx;
    logic              host_irq, chan_idle;
    logic [31:0]       status_word;
    logic [OVF_W-1:0]  ovf_cnt;

    int checks = 0;
    int errors = 0;

    // Reference state
    logic [31:0] m_cfg = '0;
    int m_widx = 0, m_rd = 0, m_last = 0, m_fill = 0, m_tcnt = 0, m_ovf = 0;
    bit m_inf = 0, m_drop = 0, m_irq = 0;

    rx_ring_ctrl #(.IDX_W(IDX_W), .BCNT_W(BCNT_W), .OVF_W(OVF_W)) i_rx_ring_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .widx_wr(widx_wr), .widx_wdata(widx_wdata), .frm_valid(frm_valid),
        .frm_sof(frm_sof), .frm_eof(frm_eof), .frm_bytes(frm_bytes),
        .tick_32us(tick_32us), .last_idx(last_idx), .host_irq(host_irq),
        .chan_idle(chan_idle), .status_word(status_word), .ovf_cnt(ovf_cnt)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int ring_mask(input logic [31:0] c);
        int lg = int'(c[23:20]);
        if (lg < 5) lg = 5;
        if (lg > 12) lg = 12;
        return (1 << lg) - 1;
    endfunction

    task automatic model_step();
        int mode, mask, cap, tmo, dst, nrd, ntc, nfill;
        bit fn, fx, acc, close, ovf_inc, nin, ndrop;
        mode = int'(m_cfg[31:30]);
        mask = ring_mask(m_cfg);
        cap  = (int'(m_cfg[17:16]) + 1) * 4096;
        tmo  = int'(m_cfg[11:4]);
        dst  = int'(m_cfg[13:12]);
        fn   = ((m_rd ^ m_widx) & mask) != 0;
        nrd  = (m_rd + 1) & mask;
        fx   = ((nrd ^ m_widx) & mask) != 0;
        acc = 0; ovf_inc = 0; close = 0; nin = m_inf; ndrop = m_drop;
        if (mode == 0 || mode == 3) begin
            nin = 0; ndrop = 0;
        end else if (frm_valid && frm_sof) begin
            acc = (mode == 2) && fn;
            nin = acc && !frm_eof;
            ndrop = !acc && !frm_eof;
            if (mode == 2 && !fn) ovf_inc = 1;
        end else if (frm_valid) begin
            acc = m_inf;
            if (frm_eof) begin nin = 0; ndrop = 0; end
        end
        ntc = m_tcnt; nfill = m_fill;
        if (acc) begin
            ntc = 0;
            if (m_fill + int'(frm_bytes) >= cap) begin close = 1; nfill = 0; end
            else nfill = m_fill + int'(frm_bytes);
        end else if (tick_32us && m_fill != 0 && tmo != 0) begin
            if (m_tcnt + 1 == tmo) begin close = 1; nfill = 0; ntc = 0; end
            else ntc = m_tcnt + 1;
        end
        if (close && nin && !fx) begin nin = 0; ndrop = 1; ovf_inc = 1; end
        if (ovf_inc && m_ovf < OVF_MAX) m_ovf++;
        m_irq = close && dst == 1;
        if (close) begin m_last = m_rd & mask; m_rd = nrd; end
        if (widx_wr && widx_wdata[2:0] == 3'b000) m_widx = int'(widx_wdata) & mask;
        if (cfg_wr) m_cfg = cfg_wdata;
        m_inf = nin; m_drop = ndrop; m_fill = nfill; m_tcnt = ntc;
    endtask

    task automatic check_all();
        bit idle;
        idle = (m_cfg[31:30] != 2'b10) && !(m_cfg[31:30] == 2'b01 && m_inf);
        chk("R2 R8 last_idx", last_idx, m_last);
        chk("R7 host_irq", host_irq, m_irq);
        chk("R9 R10 R11 chan_idle", chan_idle, idle);
        chk("R4 R12 ovf_cnt", ovf_cnt, m_ovf);
        chk("R11 status_word", status_word,
            {7'b0, idle, 12'b0, 12'(m_last)});
    endtask

    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all();
        cfg_wr = 0; widx_wr = 0; frm_valid = 0; frm_sof = 0; frm_eof = 0;
        tick_32us = 0; frm_bytes = '0;
    endtask

    task automatic wr_cfg(input logic [31:0] w);
        cfg_wr = 1; cfg_wdata = w; cyc();
    endtask

    task automatic wr_widx(input int v);
        widx_wr = 1; widx_wdata = IDX_W'(v); cyc();
    endtask

    task automatic beat(input bit s, input bit e, input int n);
        frm_valid = 1; frm_sof = s; frm_eof = e; frm_bytes = BCNT_W'(n); cyc();
    endtask

    task automatic tick();
        tick_32us = 1; cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    localparam logic [31:0] CFG_RUN = 32'h8050_1030; // run, 32 entries, 4K, irq host, timeout 3
    localparam logic [31:0] CFG_EOF = 32'h4050_1030;

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 status_word", status_word, 32'h0100_0000);
        chk("R1 last_idx", last_idx, 0);
        chk("R1 host_irq", host_irq, 0);
        chk("R1 ovf_cnt", ovf_cnt, 0);
        chk("R1 chan_idle", chan_idle, 1);

        wr_cfg(CFG_RUN);
        wr_widx(12);                 // misaligned, ignored
        beat(1, 1, 10);              // ring still empty
        chk("R3 misaligned write ignored", ovf_cnt, 1);
        wr_widx(8);
        beat(1, 0, 2047);
        beat(0, 0, 2047);
        beat(0, 1, 2);               // reaches 4096
        chk("R5 close at capacity irq", host_irq, 1);
        chk("R8 closed index", last_idx, 0);
        cyc();
        chk("R7 irq one cycle", host_irq, 0);

        beat(1, 1, 100);
        tick(); tick();
        chk("R6 no close before timeout", host_irq, 0);
        tick();
        chk("R6 close on timeout", host_irq, 1);
        chk("R6 closed index", last_idx, 1);

        for (int i = 0; i < 6; i++) begin
            beat(1, 1, 50); tick(); tick(); tick();
        end
        chk("R8 last before full", last_idx, 7);
        beat(1, 1, 10);
        chk("R4 full ring drops frame", ovf_cnt, 2);

        wr_widx(16);
        for (int i = 0; i < 7; i++) begin
            beat(1, 1, 50); tick(); tick(); tick();
        end
        beat(1, 0, 2047);
        beat(0, 0, 2047);
        beat(0, 0, 10);              // closes 15, no next buffer
        chk("R12 mid-frame overflow", ovf_cnt, 3);
        chk("R12 closed index", last_idx, 15);
        beat(0, 0, 500);
        beat(0, 1, 5);
        chk("R12 dropped rest no close", last_idx, 15);

        wr_widx(24);
        beat(1, 0, 100);
        wr_cfg(CFG_EOF);
        chk("R10 busy until eof", chan_idle, 0);
        beat(0, 0, 100);
        beat(0, 1, 100);
        chk("R10 idle after eof", chan_idle, 1);
        beat(1, 1, 10);
        chk("R10 refused not counted", ovf_cnt, 3);

        wr_cfg(CFG_RUN);
        beat(1, 0, 100);
        wr_cfg(32'h0);
        chk("R11 zero config idle", chan_idle, 1);
        beat(0, 0, 2047);
        beat(0, 1, 2047);
        chk("R9 stopped beats ignored", host_irq, 0);

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 5) begin
                logic [31:0] w;
                int m, lg;
                m = int'($urandom % 10);
                lg = int'($urandom % 5);
                w = '0;
                w[31:30] = (m < 7) ? 2'b10 : (m < 8) ? 2'b01 : (m < 9) ? 2'b00 : 2'b11;
                w[23:20] = (lg == 0) ? 4'd2 : (lg == 4) ? 4'd13 : (lg == 3) ? 4'd6 : 4'd5;
                w[17:16] = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
                w[13:12] = 2'($urandom % 2);
                w[11:4]  = 8'($urandom % 6);
                cfg_wr = 1; cfg_wdata = w;
            end else if (r < 15) begin
                widx_wr = 1;
                widx_wdata = ($urandom % 5 == 0) ? IDX_W'($urandom) : IDX_W'(($urandom % 16) * 8);
            end
            if ($urandom % 10 < 6) begin
                frm_valid = 1;
                frm_sof = ($urandom % 5 == 0);
                frm_eof = ($urandom % 4 == 0);
                frm_bytes = BCNT_W'($urandom % 2048);
            end
            tick_32us = ($urandom % 5 == 0);
            cyc();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule